// File: doc/BRIEF.md
# CAN Error Flag and Code Capture

This block is the error-reporting front of a CAN controller. The protocol engine hands it single-cycle event pulses for eight error conditions. Each pulse sets a sticky flag. Software clears a flag by writing 0 to its position. A per-source enable register decides which of these flags contribute to one summary bit. That summary bit sits in a shared interrupt status register, and a separate interrupt-enable bit gates it onto the interrupt line.

When a bus error is reported, the engine also supplies a vector of error-type bits. The block stores that vector in an error-code register, which works in one of two ways:
- In latest mode, each new bus error replaces the stored codes.
- In accumulate mode, new codes are ORed onto the stored ones until software clears them.

The engine's transmit and receive error counts can be read through the same byte-wide register port. The counts are read-only.

Top module: `can_err_capture`

## Requirements
- R1: After reset the flag, source-enable, error-code and interrupt-enable registers read 0, the display mode is 0 (latest), and `errIrq` is low.
- R2: A 1 on `errEvent[i]` sets flag bit i, readable at address 0 from the next cycle on. The flag bits from 7 down to 0 are: bus lock, overload frame sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R3: A write to address 0 clears each flag bit whose write-data bit is 0 and leaves each flag bit whose write-data bit is 1 unchanged.
- R4: If an event arrives in the same cycle as a write that clears that flag, the flag stays set.
- R5: The source-enable register at address 1 uses the flag bit layout and reads back the value last written.
- R6: Bit 5 of the status register at address 5 equals the OR over all sources of (flag AND enable). It drops as soon as no enabled flag remains set. All other status bits read 0.
- R7: The interrupt-enable register at address 6 stores only bit 5, and its other bits read 0. `errIrq` is high exactly when status bit 5 and interrupt-enable bit 5 are both 1.
- R8: The error-code register at address 2 holds the codes in bits 6 to 0. From 6 down to 0 these are: ACK delimiter, dominant bit, recessive bit, CRC, ACK, form, stuff. With display mode 0, a bus error (`errEvent[0]`) replaces bits 6 to 0 with `errCode`.
- R9: With display mode 1, a bus error ORs `errCode` into the stored codes.
- R10: A write to address 2 loads bit 7 (display mode) directly and clears each code bit whose write-data bit is 0.
- R11: Addresses 3 and 4 return `txErrCnt` and `rxErrCnt`. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errEvent | input | 8 | Error event pulses from the protocol engine, one per flag |
| errCode | input | 7 | Bus error type bits, sampled when `errEvent[0]` is 1 |
| txErrCnt | input | 8 | Transmit error count from the engine |
| rxErrCnt | input | 8 | Receive error count from the engine |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr`, combinational |
| errIrq | output | 1 | Gated summary error interrupt |

## Verification
The assertions assume that `errCode` is meaningful only in a cycle where `errEvent[0]` is 1. They also assume that event pulses are sampled at the clock edge and need no extra qualification. The flag-hold property treats every cycle without an event and without a write to address 0 as quiet, so the checks on `errEvent` rely on that input being clean at the edge. The stimulus therefore changes events, codes and writes only at the falling edge, holds each for one full cycle and drives `errCode` to 0 whenever no bus error is presented. The one deliberate overlap of an event with a clearing write is the same-cycle case that R4 defines.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 3;
  localparam int SUM_BIT  = 5;
  localparam int MODE_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FLAG = 3'd0,
    SEL_EN   = 3'd1,
    SEL_CODE = 3'd2,
    SEL_TXC  = 3'd3,
    SEL_RXC  = 3'd4,
    SEL_STAT = 3'd5,
    SEL_IE   = 3'd6,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic             flagWr;
    logic             enWr;
    logic             codeWr;
    logic             ieWr;
    logic [REG_W-1:0] data;
  } wrStrobe_t;
endpackage

// File: rtl/can_err_ctrl.sv
module can_err_ctrl
  import can_err_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CODE_W  = 7,
  parameter int CNT_W   = 8
) (
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWdata,
  input  logic [NUM_SRC-1:0]  flagQ,
  input  logic [NUM_SRC-1:0]  enQ,
  input  logic [CODE_W-1:0]   codeQ,
  input  logic                modeQ,
  input  logic                ieQ,
  input  logic                sumFlag,
  input  logic [CNT_W-1:0]    txErrCnt,
  input  logic [CNT_W-1:0]    rxErrCnt,
  output wrStrobe_t           strobe,
  output logic [REG_W-1:0]    regRdata
);
  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  // write decode: one strobe per writable register
  always_comb begin
    strobe      = '0;
    strobe.data = regWdata;
    if (regWe) begin
      unique case (sel)
        SEL_FLAG: strobe.flagWr = 1'b1;
        SEL_EN:   strobe.enWr   = 1'b1;
        SEL_CODE: strobe.codeWr = 1'b1;
        SEL_IE:   strobe.ieWr   = 1'b1;
        default:  ;
      endcase
    end
  end

  // read mux
  always_comb begin
    regRdata = '0;
    unique case (sel)
      SEL_FLAG: regRdata = REG_W'(flagQ);
      SEL_EN:   regRdata = REG_W'(enQ);
      SEL_CODE: begin
        regRdata[CODE_W-1:0] = codeQ;
        regRdata[MODE_BIT]   = modeQ;
      end
      SEL_TXC:  regRdata = REG_W'(txErrCnt);
      SEL_RXC:  regRdata = REG_W'(rxErrCnt);
      SEL_STAT: regRdata[SUM_BIT] = sumFlag;
      SEL_IE:   regRdata[SUM_BIT] = ieQ;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/can_err_dp.sv
module can_err_dp
  import can_err_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CODE_W  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          strobe,
  input  logic [NUM_SRC-1:0] errEvent,
  input  logic [CODE_W-1:0]  errCode,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic [CODE_W-1:0]  codeQ,
  output logic               modeQ,
  output logic               ieQ,
  output logic               sumFlag
);
  localparam int BUS_ERR_IDX = 0;

  logic busErr;
  assign busErr = errEvent[BUS_ERR_IDX];

  // sticky flags: event has priority over a same-cycle clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                                flagQ[i] <= 1'b0;
      else if (errEvent[i])                     flagQ[i] <= 1'b1;
      else if (strobe.flagWr && !strobe.data[i]) flagQ[i] <= 1'b0;
    end
  end

  // error code store: replace or accumulate depending on display mode
  for (genvar j = 0; j < CODE_W; j++) begin : g_code
    logic keepBit;
    assign keepBit = !(strobe.codeWr && !strobe.data[j]);
    always_ff @(posedge clk) begin
      if (!rstN)         codeQ[j] <= 1'b0;
      else if (busErr)   codeQ[j] <= modeQ ? ((codeQ[j] & keepBit) | errCode[j]) : errCode[j];
      else if (!keepBit) codeQ[j] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= 1'b0;
      enQ   <= '0;
      ieQ   <= 1'b0;
    end else begin
      if (strobe.codeWr) modeQ <= strobe.data[MODE_BIT];
      if (strobe.enWr)   enQ   <= strobe.data[NUM_SRC-1:0];
      if (strobe.ieWr)   ieQ   <= strobe.data[SUM_BIT];
    end
  end

  assign sumFlag = |(flagQ & enQ);
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
  import can_err_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CODE_W  = 7,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] errEvent,
  input  logic [CODE_W-1:0]  errCode,
  input  logic [CNT_W-1:0]   txErrCnt,
  input  logic [CNT_W-1:0]   rxErrCnt,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  output logic               errIrq
);
  wrStrobe_t          strobe;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] enQ;
  logic [CODE_W-1:0]  codeQ;
  logic               modeQ;
  logic               ieQ;
  logic               sumFlag;

  can_err_ctrl #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .flagQ(flagQ), .enQ(enQ), .codeQ(codeQ), .modeQ(modeQ), .ieQ(ieQ),
    .sumFlag(sumFlag), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .strobe(strobe), .regRdata(regRdata)
  );

  can_err_dp #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .errEvent(errEvent), .errCode(errCode),
    .flagQ(flagQ), .enQ(enQ), .codeQ(codeQ), .modeQ(modeQ), .ieQ(ieQ), .sumFlag(sumFlag)
  );

  assign errIrq = sumFlag & ieQ;
endmodule

// File: rtl/can_err_checker.sv
module can_err_checker #(
  parameter int NUM_SRC = 8,
  parameter int CODE_W  = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] errEvent,
  input logic [CODE_W-1:0]  errCode,
  input logic               regWe,
  input logic [2:0]         regAddr,
  input logic [NUM_SRC-1:0] flagQ,
  input logic [NUM_SRC-1:0] enQ,
  input logic [CODE_W-1:0]  codeQ,
  input logic               modeQ,
  input logic               errIrq
);
  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (|errEvent) |=> ((flagQ & $past(errEvent)) == $past(errEvent))); // R4

  AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagQ & ~$past(flagQ) & ~$past(errEvent)) == '0)); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!(|errEvent) && !(regWe && regAddr == 3'd0)) |=> $stable(flagQ)); // R3

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> ((flagQ & enQ) != '0)); // R7

  AST_REPLACE_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (errEvent[0] && !modeQ) |=> (codeQ == $past(errCode))); // R8

  AST_ACCUM_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (errEvent[0] && modeQ) |=> ((codeQ & $past(errCode)) == $past(errCode))); // R9
endmodule

bind can_err_capture can_err_checker #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .errEvent(errEvent), .errCode(errCode),
  .regWe(regWe), .regAddr(regAddr), .flagQ(flagQ), .enQ(enQ),
  .codeQ(codeQ), .modeQ(modeQ), .errIrq(errIrq)
);

// File: tb/can_err_capture_bench.sv
module can_err_capture_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] errEvent = '0;
  logic [6:0] errCode = '0;
  logic [7:0] txErrCnt = 8'h12;
  logic [7:0] rxErrCnt = 8'h34;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       errIrq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  can_err_capture u_can_err_capture (
    .clk(clk), .rstN(rstN), .errEvent(errEvent), .errCode(errCode),
    .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .errIrq(errIrq)
  );

  // {we, addr, wdata, evt, code, raddr, expected, req}
  localparam int NV = 15;
  localparam logic [41:0] VECS [0:NV-1] = '{
    {1'b0, 3'd0, 8'h00, 8'h01, 7'h08, 3'd0, 8'h01, 4'd2},  // R2 bus error flag
    {1'b0, 3'd0, 8'h00, 8'h80, 7'h00, 3'd0, 8'h81, 4'd2},  // R2 bus lock flag
    {1'b1, 3'd0, 8'hFE, 8'h00, 7'h00, 3'd0, 8'h80, 4'd3},  // R3 clear bit 0 only
    {1'b1, 3'd1, 8'h84, 8'h00, 7'h00, 3'd1, 8'h84, 4'd5},  // R5 enable readback
    {1'b0, 3'd0, 8'h00, 8'h00, 7'h00, 3'd5, 8'h20, 4'd6},  // R6 summary set
    {1'b0, 3'd0, 8'h00, 8'h02, 7'h00, 3'd0, 8'h82, 4'd2},  // R2 warning flag
    {1'b1, 3'd0, 8'h7F, 8'h00, 7'h00, 3'd5, 8'h00, 4'd6},  // R6 summary clears
    {1'b0, 3'd0, 8'h00, 8'h00, 7'h00, 3'd2, 8'h08, 4'd8},  // R8 CRC code kept
    {1'b0, 3'd0, 8'h00, 8'h01, 7'h40, 3'd2, 8'h40, 4'd8},  // R8 replaced
    {1'b1, 3'd2, 8'hFF, 8'h00, 7'h00, 3'd2, 8'hC0, 4'd10}, // R10 mode set
    {1'b0, 3'd0, 8'h00, 8'h01, 7'h01, 3'd2, 8'hC1, 4'd9},  // R9 accumulate
    {1'b1, 3'd2, 8'hFE, 8'h00, 7'h00, 3'd2, 8'hC0, 4'd10}, // R10 clear stuff
    {1'b1, 3'd3, 8'hAA, 8'h00, 7'h00, 3'd3, 8'h12, 4'd11}, // R11 tx count
    {1'b1, 3'd4, 8'h55, 8'h00, 7'h00, 3'd4, 8'h34, 4'd11}, // R11 rx count
    {1'b1, 3'd6, 8'hFF, 8'h00, 7'h00, 3'd6, 8'h20, 4'd7}   // R7 ie bit only
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] wd,
                      input logic [7:0] ev, input logic [6:0] cd);
    @(negedge clk);
    regWe = we; regAddr = a; regWdata = wd; errEvent = ev; errCode = cd;
    @(negedge clk);
    regWe = 1'b0; errEvent = '0; errCode = '0;
  endtask

  task automatic readChk(input logic [2:0] a, input logic [7:0] exp, input string req);
    regAddr = a;
    #1;
    check(regRdata, exp, req);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readChk(3'd0, 8'h00, "R1");
    readChk(3'd1, 8'h00, "R1");
    readChk(3'd2, 8'h00, "R1");
    readChk(3'd5, 8'h00, "R1");
    readChk(3'd6, 8'h00, "R1");
    check({7'd0, errIrq}, 8'h00, "R1");

    for (int k = 0; k < NV; k++) begin
      step(VECS[k][41], VECS[k][40:38], VECS[k][37:30], VECS[k][29:22], VECS[k][21:15]);
      readChk(VECS[k][14:12], VECS[k][11:4], $sformatf("R%0d vec%0d", VECS[k][3:0], k));
    end

    // flags now 0x03, enable 0x84, ie 1: R7 interrupt gating
    check({7'd0, errIrq}, 8'h00, "R7 no enabled source");
    step(1'b1, 3'd1, 8'h01, 8'h00, 7'h00);
    readChk(3'd5, 8'h20, "R6");
    check({7'd0, errIrq}, 8'h01, "R7 irq high");
    step(1'b1, 3'd6, 8'hDF, 8'h00, 7'h00);
    check({7'd0, errIrq}, 8'h00, "R7 irq gated off");
    readChk(3'd5, 8'h20, "R7 status unaffected");

    // R4 event wins over clearing write
    step(1'b1, 3'd0, 8'h00, 8'h04, 7'h00);
    readChk(3'd0, 8'h04, "R4");
    readChk(3'd5, 8'h00, "R6 drop");

    // R10 back to latest mode, codes cleared; R8 replacement
    step(1'b1, 3'd2, 8'h00, 8'h00, 7'h00);
    readChk(3'd2, 8'h00, "R10");
    step(1'b0, 3'd0, 8'h00, 8'h01, 7'h12);
    readChk(3'd2, 8'h12, "R8");
    step(1'b0, 3'd0, 8'h00, 8'h01, 7'h04);
    readChk(3'd2, 8'h04, "R8 latest only");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule